// File: doc/BRIEF.md
# Windowed Overlapping Register File

This block holds the integer registers of a processor core as a set of overlapping windows plus a shared group of globals. Every access names a 5-bit architectural register number. A window pointer turns that number into an entry of a larger physical array. Numbers 0 to 7 are the globals and are the same in every window. Numbers 8 to 15 are the window's ins, 16 to 23 its locals, and 24 to 31 its outs. The ins of a window are the same storage as the outs of the window one above it. As a result, when a call moves the pointer down, the callee reads the caller's outs as its own ins.

There are two combinational read ports, one for each source operand. Each is served by its own copy of the storage, and every write lands in both copies. There is one synchronous write port. A call strobe moves the pointer down by one and a return strobe moves it up by one, both wrapping modulo the window count. An externally loaded invalid mask guards both moves. When the target window is marked invalid, the pointer stays where it is and a one-cycle overflow or underflow flag is raised. Saving and restoring register contents on such a condition is left to the surrounding core.

Top module: `winRegFile`

## Requirements
- R1: After reset the window pointer is 0, the invalid mask is all clear, and both the overflow and underflow flags are low.
- R2: Register 0 always reads as zero on both ports. A write to register 0 changes nothing.
- R3: Registers 1 to 7 are globals: a value written from any window reads back unchanged from every other window.
- R4: Numbers 16 to 23 (locals) and 24 to 31 (outs) are private to a window. A write to them in one window does not alter the same numbers in another window.
- R5: A call strobe with a valid target sets the pointer to pointer−1 modulo 8 at the next clock edge, so 0 wraps to 7.
- R6: Ins and outs overlap. Register 8+k in window w is the same entry as register 24+k in window w+1 modulo 8, for k from 0 to 7, in both the read and the write direction.
- R7: A return strobe with a valid target sets the pointer to pointer+1 modulo 8 at the next clock edge, so 7 wraps to 0.
- R8: When the call target window has its bit set in the mask (bit w marks window w invalid), the pointer keeps its value and the overflow flag is high for exactly the one cycle after the strobe edge.
- R9: When the return target window has its bit set in the mask, the pointer keeps its value and the underflow flag is high for exactly the one cycle after the strobe edge.
- R10: Call and return strobes asserted together have no effect: the pointer stays and neither flag rises.
- R11: When a read names the same physical entry as a write in the same cycle, that read port returns the data being written.
- R12: Both read ports return identical data whenever they name the same register.
- R13: A mask load takes effect at the clock edge. A call or return in the same cycle as the load is judged against the previous mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| raddrA | input | 5 | Architectural register number, first operand |
| raddrB | input | 5 | Architectural register number, second operand |
| rdataA | output | 32 | First operand read data |
| rdataB | output | 32 | Second operand read data |
| we | input | 1 | Write enable |
| waddr | input | 5 | Architectural register number to write |
| wdata | input | 32 | Write data |
| save | input | 1 | Call strobe, moves the pointer down |
| restore | input | 1 | Return strobe, moves the pointer up |
| wimWe | input | 1 | Load enable for the invalid mask |
| wimIn | input | 8 | New invalid mask, bit w for window w |
| cwp | output | 3 | Current window pointer |
| overflow | output | 1 | One-cycle pulse: call blocked by the mask |
| underflow | output | 1 | One-cycle pulse: return blocked by the mask |

## Verification
A wrong pointer update appears on `cwp` at the clock edge that consumes the strobe. A mask that was loaded or consulted incorrectly shows up one cycle later, as a flag that rises when it should not or stays low when it should rise. A mapping fault is silent until an overlapped or private register is read from the neighbouring window. For that reason the stimulus writes outs, moves the pointer, and reads the matching ins in the very next cycle. Mismatched mirror copies or a missing bypass show on the read data in the same cycle as the write.

// File: rtl/winrf_pkg.sv
package winrf_pkg;
  localparam int ARCH_W  = 5;
  localparam int GLOBALS = 8;
  localparam int PRIV_PER_WIN = 16;

  typedef struct packed {
    logic wrGo;   // write accepted (non-zero target)
    logic zeroA;  // operand A names register 0
    logic zeroB;  // operand B names register 0
  } rfStrobes_t;
endpackage

// File: rtl/winrf_ctrl.sv
module winrf_ctrl
  import winrf_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              save,
  input  logic              restore,
  input  logic              wimWe,
  input  logic [NWIN-1:0]   wimIn,
  input  logic              we,
  input  logic [ARCH_W-1:0] waddr,
  input  logic [ARCH_W-1:0] raddrA,
  input  logic [ARCH_W-1:0] raddrB,
  output logic [CW-1:0]     cwp,
  output logic [NWIN-1:0]   wimState,
  output logic              overflow,
  output logic              underflow,
  output rfStrobes_t        strobes
);
  logic [CW-1:0] tgtDown, tgtUp;
  logic saveOnly, restOnly, downOk, upOk;

  always_comb begin
    tgtDown  = (cwp == '0) ? CW'(NWIN - 1) : CW'(cwp - 1'b1);
    tgtUp    = (cwp == CW'(NWIN - 1)) ? '0 : CW'(cwp + 1'b1);
    saveOnly = save & ~restore;
    restOnly = restore & ~save;
    downOk   = ~wimState[tgtDown];
    upOk     = ~wimState[tgtUp];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwp       <= '0;
      wimState  <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= saveOnly & ~downOk;
      underflow <= restOnly & ~upOk;
      if (saveOnly && downOk)      cwp <= tgtDown;
      else if (restOnly && upOk)   cwp <= tgtUp;
      if (wimWe) wimState <= wimIn;
    end
  end

  always_comb begin
    strobes.wrGo  = we && (waddr != '0);
    strobes.zeroA = (raddrA == '0);
    strobes.zeroB = (raddrB == '0);
  end
endmodule

// File: rtl/winrf_data.sv
module winrf_data
  import winrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW    = $clog2(NWIN),
  localparam int NPHYS = GLOBALS + PRIV_PER_WIN * NWIN,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic              clk,
  input  logic [CW-1:0]     cwp,
  input  rfStrobes_t        strobes,
  input  logic [ARCH_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ARCH_W-1:0] raddrA,
  input  logic [ARCH_W-1:0] raddrB,
  output logic [DW-1:0]     rdataA,
  output logic [DW-1:0]     rdataB
);
  // Physical layout: globals first, then per window 8 locals followed by 8 outs.
  // The ins of window w are the outs of window w+1 (mod NWIN).
  function automatic logic [PW-1:0] mapReg(input logic [ARCH_W-1:0] r,
                                           input logic [CW-1:0] w);
    int win, slot;
    slot = int'(r[2:0]);
    win  = int'(w);
    case (r[4:3])
      2'd0: return PW'(slot);
      2'd1: return PW'(GLOBALS + PRIV_PER_WIN * ((win + 1) % NWIN) + 8 + slot);
      2'd2: return PW'(GLOBALS + PRIV_PER_WIN * win + slot);
      default: return PW'(GLOBALS + PRIV_PER_WIN * win + 8 + slot);
    endcase
  endfunction

  logic [PW-1:0] wIdx;
  logic [PW-1:0] rIdx [2];
  logic [DW-1:0] rawRd [2];
  logic          zeroSel [2];
  logic [DW-1:0] outRd [2];

  always_comb begin
    wIdx       = mapReg(waddr, cwp);
    rIdx[0]    = mapReg(raddrA, cwp);
    rIdx[1]    = mapReg(raddrB, cwp);
    zeroSel[0] = strobes.zeroA;
    zeroSel[1] = strobes.zeroB;
  end

  for (genvar c = 0; c < 2; c++) begin : g_copy
    logic [DW-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
      if (strobes.wrGo) mem[wIdx] <= wdata;
    end

    always_comb begin
      rawRd[c] = mem[rIdx[c]];
      if (zeroSel[c])                         outRd[c] = '0;
      else if (strobes.wrGo && rIdx[c] == wIdx) outRd[c] = wdata;
      else                                    outRd[c] = rawRd[c];
    end
  end

  assign rdataA = outRd[0];
  assign rdataB = outRd[1];
endmodule

// File: rtl/winRegFile.sv
module winRegFile
  import winrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ARCH_W-1:0] raddrA,
  input  logic [ARCH_W-1:0] raddrB,
  output logic [DW-1:0]     rdataA,
  output logic [DW-1:0]     rdataB,
  input  logic              we,
  input  logic [ARCH_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              save,
  input  logic              restore,
  input  logic              wimWe,
  input  logic [NWIN-1:0]   wimIn,
  output logic [CW-1:0]     cwp,
  output logic              overflow,
  output logic              underflow
);
  rfStrobes_t      strobes;
  logic [NWIN-1:0] wimState;

  winrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .save(save), .restore(restore),
    .wimWe(wimWe), .wimIn(wimIn), .we(we), .waddr(waddr),
    .raddrA(raddrA), .raddrB(raddrB), .cwp(cwp), .wimState(wimState),
    .overflow(overflow), .underflow(underflow), .strobes(strobes)
  );

  winrf_data #(.NWIN(NWIN), .DW(DW)) u_data (
    .clk(clk), .cwp(cwp), .strobes(strobes), .waddr(waddr), .wdata(wdata),
    .raddrA(raddrA), .raddrB(raddrB), .rdataA(rdataA), .rdataB(rdataB)
  );
endmodule

// File: rtl/winRegFile_checker.sv
module winRegFile_checker #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rstN,
  input logic [4:0]      raddrA,
  input logic [4:0]      raddrB,
  input logic [DW-1:0]   rdataA,
  input logic [DW-1:0]   rdataB,
  input logic            we,
  input logic [4:0]      waddr,
  input logic [DW-1:0]   wdata,
  input logic            save,
  input logic            restore,
  input logic [CW-1:0]   cwp,
  input logic            overflow,
  input logic            underflow,
  input logic [NWIN-1:0] wimState
);
  logic [CW-1:0] expDown, expUp;
  assign expDown = (cwp == '0) ? CW'(NWIN - 1) : CW'(cwp - 1'b1);
  assign expUp   = (cwp == CW'(NWIN - 1)) ? '0 : CW'(cwp + 1'b1);

  assert_r0_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (raddrA == 5'd0) |-> (rdataA == '0));

  assert_save_dec_R5: assert property (@(posedge clk) disable iff (!rstN)
    (save && !restore && !wimState[expDown]) |=> (cwp == $past(expDown)));

  assert_restore_inc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (restore && !save && !wimState[expUp]) |=> (cwp == $past(expUp)));

  assert_no_overflow_move_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> $stable(cwp));

  assert_no_underflow_move_R9: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> $stable(cwp));

  assert_both_noop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (save && restore) |=> ($stable(cwp) && !overflow && !underflow));

  assert_forward_R11: assert property (@(posedge clk) disable iff (!rstN)
    (we && waddr == raddrA && raddrA != 5'd0) |-> (rdataA == wdata));

  assert_mirror_R12: assert property (@(posedge clk) disable iff (!rstN)
    (raddrA == raddrB) |-> (rdataA == rdataB));
endmodule

bind winRegFile winRegFile_checker #(.NWIN(NWIN), .DW(DW)) u_chk (.*);

// File: tb/winRegFile_test.sv
`timescale 1ns/1ps
module winRegFile_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  raddrA = '0, raddrB = '0, waddr = '0;
  logic [31:0] rdataA, rdataB, wdata = '0;
  logic        we = 1'b0, save = 1'b0, restore = 1'b0, wimWe = 1'b0;
  logic [7:0]  wimIn = '0;
  logic [2:0]  cwp;
  logic        overflow, underflow;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // scoreboard queues: signal code, expected value, tag
  // codes: 0 rdataA, 1 rdataB, 2 cwp, 3 overflow, 4 underflow
  int          sigQ[$];
  logic [31:0] expQ[$];
  string       tagQ[$];

  winRegFile uut (
    .clk(clk), .rstN(rstN), .raddrA(raddrA), .raddrB(raddrB),
    .rdataA(rdataA), .rdataB(rdataB), .we(we), .waddr(waddr), .wdata(wdata),
    .save(save), .restore(restore), .wimWe(wimWe), .wimIn(wimIn),
    .cwp(cwp), .overflow(overflow), .underflow(underflow)
  );

  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_(int s, logic [31:0] e, string tag);
    sigQ.push_back(s);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor: compare everything queued for this cycle at the falling edge
  always @(negedge clk) begin
    while (sigQ.size() > 0) begin
      int s;
      logic [31:0] e, a;
      string t;
      s = sigQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      case (s)
        0: a = rdataA;
        1: a = rdataB;
        2: a = {29'd0, cwp};
        3: a = {31'd0, overflow};
        default: a = {31'd0, underflow};
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic wrReg(logic [4:0] a, logic [31:0] d);
    we = 1'b1; waddr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rdBoth(logic [4:0] a, logic [31:0] e, string tag);
    raddrA = a; raddrB = a;
    expect_(0, e, tag);
    expect_(1, e, tag);
    tick();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
        finishRun();
      end
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    // R1 reset state
    expect_(2, 0, "R1 cwp");
    expect_(3, 0, "R1 overflow");
    expect_(4, 0, "R1 underflow");
    tick();

    // R2: r0 write ignored, read zero (same cycle and after)
    raddrA = 5'd0; raddrB = 5'd0;
    we = 1'b1; waddr = 5'd0; wdata = 32'hDEAD_BEEF;
    expect_(0, 0, "R2 r0 during write A");
    expect_(1, 0, "R2 r0 during write B");
    tick();
    we = 1'b0;
    rdBoth(5'd0, 0, "R2 r0 after write");

    // setup in window 0
    wrReg(5'd1, 32'h0000_0011);
    wrReg(5'd16, 32'h0000_00A0);
    wrReg(5'd24, 32'h0000_00B0);
    wrReg(5'd31, 32'h0000_00B7);

    // R5 save wraps 0 -> 7
    save = 1'b1; tick(); save = 1'b0;
    expect_(2, 7, "R5 save wrap");
    expect_(3, 0, "R5 no overflow");
    // R6 callee ins see caller outs, read right after the move
    rdBoth(5'd8, 32'h0000_00B0, "R6 i0 alias o0");
    rdBoth(5'd15, 32'h0000_00B7, "R6 i7 alias o7");
    rdBoth(5'd1, 32'h0000_0011, "R3 global from window 7");
    wrReg(5'd16, 32'h0000_00C0);
    wrReg(5'd24, 32'h0000_00C8);
    wrReg(5'd9, 32'h0000_0099);   // lands in window 0 o1
    wrReg(5'd2, 32'h0000_0022);

    // R7 restore 7 -> 0
    restore = 1'b1; tick(); restore = 1'b0;
    expect_(2, 0, "R7 restore wrap");
    rdBoth(5'd16, 32'h0000_00A0, "R4 local private");
    rdBoth(5'd24, 32'h0000_00B0, "R4 out private");
    rdBoth(5'd25, 32'h0000_0099, "R6 write via in");
    rdBoth(5'd2, 32'h0000_0022, "R3 global written in window 7");

    // R7 full ring of restores
    for (int k = 1; k <= 8; k++) begin
      restore = 1'b1; tick(); restore = 1'b0;
      expect_(2, 32'(k % 8), "R7 restore step");
      tick();
    end

    // R8 overflow: window 7 invalid, save from 0
    wimWe = 1'b1; wimIn = 8'h80; tick(); wimWe = 1'b0;
    save = 1'b1; tick(); save = 1'b0;
    expect_(2, 0, "R8 cwp held");
    expect_(3, 1, "R8 overflow pulse");
    tick();
    expect_(3, 0, "R8 overflow single cycle");
    tick();

    // R9 underflow: window 1 invalid, restore from 0
    wimWe = 1'b1; wimIn = 8'h02; tick(); wimWe = 1'b0;
    restore = 1'b1; tick(); restore = 1'b0;
    expect_(2, 0, "R9 cwp held");
    expect_(4, 1, "R9 underflow pulse");
    expect_(3, 0, "R9 no overflow");
    tick();
    expect_(4, 0, "R9 underflow single cycle");
    tick();

    // R10 both strobes
    save = 1'b1; restore = 1'b1; tick(); save = 1'b0; restore = 1'b0;
    expect_(2, 0, "R10 cwp held");
    expect_(3, 0, "R10 no overflow");
    expect_(4, 0, "R10 no underflow");
    tick();

    // R13 mask load with save in same cycle: old mask 0x02 allows move to 7
    wimWe = 1'b1; wimIn = 8'h01; save = 1'b1; tick();
    wimWe = 1'b0; save = 1'b0;
    expect_(2, 7, "R13 save judged on old mask");
    expect_(3, 0, "R13 no overflow");
    tick();
    restore = 1'b1; tick(); restore = 1'b0;
    expect_(2, 7, "R13 new mask blocks restore");
    expect_(4, 1, "R13 underflow from new mask");
    tick();

    // R11 write-first on both ports, R12 mirror
    raddrA = 5'd20; raddrB = 5'd20;
    we = 1'b1; waddr = 5'd20; wdata = 32'h5555_AAAA;
    expect_(0, 32'h5555_AAAA, "R11 bypass A");
    expect_(1, 32'h5555_AAAA, "R11 bypass B");
    tick();
    we = 1'b0;
    rdBoth(5'd20, 32'h5555_AAAA, "R12 mirror after write");
    rdBoth(5'd16, 32'h0000_00C0, "R4 window 7 local kept");

    tick();
    done = 1;
    finishRun();
  end
endmodule